// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 peripheral interrupt lines and presents one interrupt request to a processor. Each line has a sense mode chosen at build time: rising edge, falling edge, level high or level low. Every line passes through a synchronizer. A qualifying event on a line sets that line's bit in a status register, and the bit stays set until software acknowledges it. For level-sensed lines the bit is set again for as long as the level stays active.

Software reaches the block through a plain 32-bit read/write port with byte addresses on word boundaries. It can write the enable mask directly, or change individual bits through a write-1-to-set alias and a write-1-to-clear alias. It can also acknowledge captured events, read back the status and the masked pending set, and read a vector register that returns the number of the highest-priority pending line. A two-bit master enable must be fully on before the processor request can rise. The service routine reads the vector, handles that line, acknowledges it, and reads the vector again until no line is pending.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the status, pending, enable and master registers read as zero, the vector reads as 0xFFFFFFFF, and irq_out is low.
- R2: The sense of line n is SENSE_MAP[2n+1:2n], with 0 = rising edge, 1 = falling edge, 2 = level high and 3 = level low. A qualifying change on irq_in sets status bit n at the third rising clock edge after the change. The opposite edge of an edge-sensed line sets nothing.
- R3: The pending register (offset 0x04) reads as status AND enable, bit n for line n.
- R4: A write to the enable register (offset 0x08) replaces the mask. A write to offset 0x10 ORs the 1 bits of the written word into the mask. A write to offset 0x14 clears the mask bits where the written word has 1s. Zero bits of either alias leave the mask unchanged.
- R5: Writing 1 to bit n of the acknowledge register (offset 0x0C) clears status bit n, and writing all ones clears every captured bit.
- R6: When a capture event and an acknowledge hit the same bit in the same cycle, the bit stays set. A level-sensed bit that is acknowledged while its level is still active reads as set again.
- R7: The master register (offset 0x1C) holds bits [1:0] of the written word and reads with bits [31:2] zero. irq_out is high only while the master value is 3 and at least one pending bit is set.
- R8: The vector register (offset 0x18) reads as the lowest-numbered pending line, or as 0xFFFFFFFF when nothing is pending.
- R9: Writes to offsets 0x00, 0x04 and 0x18 have no effect. Offsets 0x0C, 0x10 and 0x14 read as zero. Bits above the line count read as zero. An access whose address bits [1:0] are not zero writes nothing and reads as zero.
- R10: bus_rdata loads the addressed register at the clock edge that samples bus_rd high, and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_LINES | Peripheral interrupt lines |
| bus_addr | input | 5 | Byte address of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A change on an interrupt line reaches the status bit, and with it irq_out, at the third rising edge after the change. The bench samples irq_out at each of the first three falling edges so that a stage too many or too few shows up. Register writes take effect at the edge that samples the strobe, and read data appears one edge after bus_rd, so each read check samples at the falling edge that follows that edge. A behavioural model runs alongside the design and predicts irq_out and bus_rdata for every cycle. Its predictions are compared with the design's outputs on every falling edge, which also covers the cycles between directed checks and a long random phase.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam int MAX_LINES = 32;
   localparam int DATA_W    = 32;
   localparam int BUS_AW    = 5;

   typedef enum logic [1:0] {
      SENSE_RISE = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_HIGH = 2'd2,
      SENSE_LOW  = 2'd3
   } sense_e;

   typedef enum logic [2:0] {
      OFS_STATUS = 3'd0,
      OFS_PEND   = 3'd1,
      OFS_ENABLE = 3'd2,
      OFS_ACK    = 3'd3,
      OFS_SETEN  = 3'd4,
      OFS_CLREN  = 3'd5,
      OFS_VECTOR = 3'd6,
      OFS_MASTER = 3'd7
   } reg_idx_e;

   localparam logic [1:0] MASTER_ON = 2'b11;

endpackage

// File: rtl/vic_line_cap.sv
module vic_line_cap
   import vic_pkg::*;
#(
   parameter sense_e SENSE       = SENSE_RISE,
   parameter int     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic event_o
);

   localparam logic IDLE_LVL = (SENSE == SENSE_LOW);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vic_line_cap: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LVL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
   end

   assign line_sync = sync_q[SYNC_STAGES-1];

   // Edge modes compare with the previous synchronized sample; level modes pass through.
   case (SENSE)
      SENSE_RISE, SENSE_FALL: begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= IDLE_LVL;
            end else begin
               prev_q <= line_sync;
            end
         end
         if (SENSE == SENSE_RISE) begin : g_rise
            assign event_o = line_sync & ~prev_q;
         end else begin : g_fall
            assign event_o = ~line_sync & prev_q;
         end
      end
      SENSE_HIGH: begin : g_lvl_hi
         assign event_o = line_sync;
      end
      default: begin : g_lvl_lo
         assign event_o = ~line_sync;
      end
   endcase

endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   if ((1 << IDX_W) < N) begin : g_bad_idx
      $error("vic_prio_enc: IDX_W too narrow for N");
   end

   // Scan from the top down so the lowest set index is the last assignment.
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
   import vic_pkg::*;
#(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic [N-1:0]      cap_event,
   input  logic              vec_found,
   input  logic [IDX_W-1:0]  vec_idx,
   output logic [N-1:0]      status_q,
   output logic [N-1:0]      enable_q,
   output logic [1:0]        master_q,
   output logic [N-1:0]      pend_o,
   output logic [DATA_W-1:0] bus_rdata
);

   if (N > DATA_W) begin : g_bad_n
      $error("vic_regfile: N exceeds data width");
   end

   reg_idx_e          word_sel;
   logic              aligned;
   logic              wr_hit;
   logic [N-1:0]      wmask;
   logic [N-1:0]      ack_mask;
   logic [DATA_W-1:0] rd_word;

   function automatic logic [DATA_W-1:0] widen_mask(input logic [N-1:0] v);
      logic [DATA_W-1:0] w;
      w        = '0;
      w[N-1:0] = v;
      return w;
   endfunction

   function automatic logic [DATA_W-1:0] widen_idx(input logic [IDX_W-1:0] v);
      logic [DATA_W-1:0] w;
      w            = '0;
      w[IDX_W-1:0] = v;
      return w;
   endfunction

   assign word_sel = reg_idx_e'(bus_addr[BUS_AW-1:2]);
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign wr_hit   = bus_wr && aligned;
   assign wmask    = bus_wdata[N-1:0];
   assign ack_mask = (wr_hit && word_sel == OFS_ACK) ? wmask : '0;
   assign pend_o   = status_q & enable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         master_q <= '0;
      end else if (wr_hit) begin
         case (word_sel)
            OFS_ENABLE: enable_q <= wmask;
            OFS_SETEN:  enable_q <= enable_q | wmask;
            OFS_CLREN:  enable_q <= enable_q & ~wmask;
            OFS_MASTER: master_q <= bus_wdata[1:0];
            default: ;
         endcase
      end
   end

   // A fresh capture event outranks an acknowledge of the same bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= (status_q & ~ack_mask) | cap_event;
      end
   end

   always_comb begin
      rd_word = '0;
      if (aligned) begin
         case (word_sel)
            OFS_STATUS: rd_word = widen_mask(status_q);
            OFS_PEND:   rd_word = widen_mask(pend_o);
            OFS_ENABLE: rd_word = widen_mask(enable_q);
            OFS_VECTOR: rd_word = vec_found ? widen_idx(vec_idx) : '1;
            OFS_MASTER: rd_word = {{(DATA_W-2){1'b0}}, master_q};
            default:    rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_word;
      end
   end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
   import vic_pkg::*;
#(
   parameter int                       N_LINES     = 32,
   parameter logic [2*MAX_LINES-1:0]   SENSE_MAP   = '0,
   parameter int                       SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_rd,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);

   localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

   if (N_LINES < 1 || N_LINES > MAX_LINES) begin : g_bad_lines
      $error("vic_ctrl: N_LINES must be between 1 and 32");
   end

   logic [N_LINES-1:0] cap_event;
   logic [N_LINES-1:0] status_q;
   logic [N_LINES-1:0] enable_q;
   logic [N_LINES-1:0] pend;
   logic [1:0]         master_q;
   logic               vec_found;
   logic [IDX_W-1:0]   vec_idx;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      vic_line_cap #(
         .SENSE       (sense_e'(SENSE_MAP[2*i +: 2])),
         .SYNC_STAGES (SYNC_STAGES)
      ) cap_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (irq_in[i]),
         .event_o (cap_event[i])
      );
   end

   vic_regfile #(
      .N     (N_LINES),
      .IDX_W (IDX_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .cap_event (cap_event),
      .vec_found (vec_found),
      .vec_idx   (vec_idx),
      .status_q  (status_q),
      .enable_q  (enable_q),
      .master_q  (master_q),
      .pend_o    (pend),
      .bus_rdata (bus_rdata)
   );

   vic_prio_enc #(
      .N     (N_LINES),
      .IDX_W (IDX_W)
   ) prio_i (
      .req   (pend),
      .found (vec_found),
      .idx   (vec_idx)
   );

   assign irq_out = (master_q == MASTER_ON) && vec_found;

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
   parameter int N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [4:0]   bus_addr,
   input logic         bus_wr,
   input logic [31:0]  bus_wdata,
   input logic         bus_rd,
   input logic [31:0]  bus_rdata,
   input logic         irq_out,
   input logic [N-1:0] cap_event,
   input logic [N-1:0] status_q,
   input logic [N-1:0] enable_q
);

   assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'h10) |=>
         ((enable_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

   assert_clear_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'h14) |=>
         ((enable_q & $past(bus_wdata[N-1:0])) == '0));

   assert_ack_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'h0C && bus_wdata[N-1:0] == '1 && cap_event == '0) |=>
         (status_q == '0));

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|cap_event) |=> ((status_q & $past(cap_event)) == $past(cap_event)));

   assert_master_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'h1C && bus_wdata[1:0] != 2'b11) |=> !irq_out);

   assert_idle_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 5'h18 && (status_q & enable_q) == '0) |=>
         (bus_rdata == 32'hFFFF_FFFF));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

bind vic_ctrl vic_ctrl_chk #(.N(N_LINES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .cap_event (cap_event),
   .status_q  (status_q),
   .enable_q  (enable_q)
);

// File: tb/vic_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic_ctrl_tb_top;

   localparam int          N       = 8;
   // line: 7=fall 6=high 5=rise 4=low 3=high 2=fall 1=rise 0=rise
   localparam logic [63:0] SMAP    = 64'h6390;
   localparam logic [7:0]  IDLE_IN = 8'h94;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = IDLE_IN;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   vic_ctrl #(.N_LINES(N), .SENSE_MAP(SMAP)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   // ---------------- behavioural reference model ----------------
   logic [N-1:0] m_s1, m_s2, m_prev, m_status, m_en;
   logic [1:0]   m_mer;
   logic [31:0]  m_rdata;
   logic         m_irq;

   function automatic int mode_of(int i);
      return int'(SMAP[2*i +: 2]);
   endfunction

   function automatic logic [N-1:0] reset_level();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = (mode_of(i) == 3);
      return r;
   endfunction

   function automatic logic [31:0] model_read(logic [4:0] a);
      logic [N-1:0] p;
      p = m_status & m_en;
      if (a[1:0] != 2'b00) return 32'h0;
      case (a[4:2])
         3'd0: return 32'(m_status);
         3'd1: return 32'(p);
         3'd2: return 32'(m_en);
         3'd6: begin
            for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
            return 32'hFFFF_FFFF;
         end
         3'd7: return {30'h0, m_mer};
         default: return 32'h0;
      endcase
   endfunction

   assign m_irq = (m_mer == 2'b11) && (|(m_status & m_en));

   always @(posedge clk or negedge rst_n) begin : model
      logic [N-1:0] ev;
      logic [N-1:0] ack;
      logic [N-1:0] wd;
      if (!rst_n) begin
         m_s1 <= reset_level(); m_s2 <= reset_level(); m_prev <= reset_level();
         m_status <= '0; m_en <= '0; m_mer <= '0; m_rdata <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            case (mode_of(i))
               0: ev[i] = m_s2[i] && !m_prev[i];
               1: ev[i] = !m_s2[i] && m_prev[i];
               2: ev[i] = m_s2[i];
               default: ev[i] = !m_s2[i];
            endcase
         end
         wd  = bus_wdata[N-1:0];
         ack = (bus_wr && bus_addr == 5'h0C) ? wd : '0;
         m_status <= (m_status & ~ack) | ev;
         if (bus_wr && bus_addr[1:0] == 2'b00) begin
            case (bus_addr[4:2])
               3'd2: m_en <= wd;
               3'd4: m_en <= m_en | wd;
               3'd5: m_en <= m_en & ~wd;
               3'd7: m_mer <= bus_wdata[1:0];
               default: ;
            endcase
         end
         if (bus_rd) m_rdata <= model_read(bus_addr);
         m_prev <= m_s2;
         m_s2   <= m_s1;
         m_s1   <= irq_in;
      end
   end

   // ---------------- checking ----------------
   task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "model irq_out", 32'(irq_out), 32'(m_irq));
         check(cur_req, "model bus_rdata", bus_rdata, m_rdata);
      end
   end

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, "read", bus_rdata, exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin : stim
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      cur_req = "R1";
      check("R1", "irq_out after reset", 32'(irq_out), 32'h0);
      rd_chk("R1", 5'h00, 32'h0);
      rd_chk("R1", 5'h04, 32'h0);
      rd_chk("R1", 5'h08, 32'h0);
      rd_chk("R1", 5'h1C, 32'h0);
      rd_chk("R1", 5'h18, 32'hFFFF_FFFF);

      // R2 capture latency: status and irq_out at the third edge
      cur_req = "R2";
      wr(5'h08, 32'h20);
      wr(5'h1C, 32'h3);
      @(negedge clk); irq_in[5] = 1'b1;
      @(negedge clk); check("R2", "irq_out edge 1", 32'(irq_out), 32'h0);
      @(negedge clk); check("R2", "irq_out edge 2", 32'(irq_out), 32'h0);
      @(negedge clk); check("R2", "irq_out edge 3", 32'(irq_out), 32'h1);
      irq_in[5] = 1'b0;

      // R2 each sense mode
      @(negedge clk); irq_in[0] = 1'b1;
      @(negedge clk); irq_in[0] = 1'b0;
      idle(4);
      @(negedge clk); irq_in[2] = 1'b0;
      @(negedge clk); irq_in[2] = 1'b1;
      idle(4);
      rd_chk("R2", 5'h00, 32'h25);
      irq_in[3] = 1'b1; idle(4);
      irq_in[4] = 1'b0; idle(4);
      rd_chk("R2", 5'h00, 32'h3D);

      // R5 acknowledge, R6 level re-capture
      cur_req = "R5";
      wr(5'h0C, 32'h21);
      rd_chk("R5", 5'h00, 32'h1C);
      cur_req = "R6";
      wr(5'h0C, 32'hFFFF_FFFF);
      rd_chk("R6", 5'h00, 32'h18);
      irq_in[3] = 1'b0; irq_in[4] = 1'b1;
      idle(4);
      cur_req = "R5";
      wr(5'h0C, 32'hFFFF_FFFF);
      rd_chk("R5", 5'h00, 32'h0);

      // R6 edge event in the same cycle as its acknowledge
      cur_req = "R6";
      @(negedge clk); irq_in[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h2;
      @(negedge clk); bus_wr = 1'b0;
      rd_chk("R6", 5'h00, 32'h2);
      wr(5'h0C, 32'h2);
      rd_chk("R6", 5'h00, 32'h0);
      irq_in[1] = 1'b0;

      // R4 enable register and aliases
      cur_req = "R4";
      wr(5'h08, 32'h0F);       rd_chk("R4", 5'h08, 32'h0F);
      wr(5'h10, 32'h30);       rd_chk("R4", 5'h08, 32'h3F);
      wr(5'h14, 32'h05);       rd_chk("R4", 5'h08, 32'h3A);
      wr(5'h08, 32'h0);        rd_chk("R4", 5'h08, 32'h0);
      wr(5'h08, 32'hFFFF_FFFF); rd_chk("R9", 5'h08, 32'hFF);
      wr(5'h14, 32'hFFFF_FFF0); rd_chk("R4", 5'h08, 32'h0F);
      wr(5'h08, 32'h0);

      // R3 pending, R8 vector priority
      cur_req = "R3";
      @(negedge clk); irq_in[0] = 1'b1; irq_in[5] = 1'b1; irq_in[7] = 1'b0;
      @(negedge clk); irq_in[0] = 1'b0; irq_in[5] = 1'b0; irq_in[7] = 1'b1;
      idle(4);
      rd_chk("R3", 5'h00, 32'hA1);
      wr(5'h08, 32'h21);
      rd_chk("R3", 5'h04, 32'h21);
      cur_req = "R8";
      rd_chk("R8", 5'h18, 32'h0);
      wr(5'h0C, 32'h1);
      rd_chk("R8", 5'h18, 32'h5);
      rd_chk("R3", 5'h04, 32'h20);
      wr(5'h08, 32'h0);
      rd_chk("R8", 5'h18, 32'hFFFF_FFFF);

      // R7 master enable gating
      cur_req = "R7";
      check("R7", "irq_out no enable", 32'(irq_out), 32'h0);
      wr(5'h1C, 32'h0);
      wr(5'h08, 32'h80);
      check("R7", "irq_out master 0", 32'(irq_out), 32'h0);
      wr(5'h1C, 32'h1);
      check("R7", "irq_out master 1", 32'(irq_out), 32'h0);
      rd_chk("R7", 5'h1C, 32'h1);
      wr(5'h1C, 32'h2);
      check("R7", "irq_out master 2", 32'(irq_out), 32'h0);
      wr(5'h1C, 32'h3);
      check("R7", "irq_out master 3", 32'(irq_out), 32'h1);
      wr(5'h1C, 32'hFFFF_FFFF);
      rd_chk("R7", 5'h1C, 32'h3);

      // R9 read-only and unmapped accesses
      cur_req = "R9";
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'h0);
      wr(5'h18, 32'h0);
      rd_chk("R9", 5'h00, 32'hA0);
      rd_chk("R9", 5'h04, 32'h80);
      rd_chk("R9", 5'h08, 32'h80);
      rd_chk("R9", 5'h0C, 32'h0);
      rd_chk("R9", 5'h10, 32'h0);
      rd_chk("R9", 5'h14, 32'h0);
      wr(5'h09, 32'hFF);
      rd_chk("R9", 5'h08, 32'h80);
      rd_chk("R9", 5'h0A, 32'h0);

      // R10 read data holds while no read is issued
      cur_req = "R10";
      rd_chk("R10", 5'h18, 32'h7);
      wr(5'h0C, 32'hFFFF_FFFF);
      idle(2);
      check("R10", "held rdata", bus_rdata, 32'h7);
      rd_chk("R10", 5'h18, 32'hFFFF_FFFF);

      // random traffic against the model
      cur_req = "R2";
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         irq_in    = N'($urandom);
         bus_wr    = ($urandom % 4) == 0;
         bus_rd    = ($urandom % 2) == 0;
         bus_addr  = {3'($urandom), (($urandom % 16) == 0) ? 2'b01 : 2'b00};
         bus_wdata = $urandom;
      end
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; irq_in = IDLE_IN;
      idle(3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule